// File: doc/BRIEF.md
# Interleaved Banked Memory Controller

This block is a word-addressed memory of 64-bit words split into sixteen independent banks. The low-order address bits pick the bank, so neighbouring words live in neighbouring banks. A bank that has just been read or written needs several clock cycles to recover. A bank in recovery is busy and cannot take another access until the recovery time has run out.

A vector transfer is requested with a start pulse, a direction (load or store), a first address, an element count and a stride. The controller walks the element addresses strictly in index order. It issues one element per cycle while each element's bank is idle, and it stalls when the next bank is still recovering. Load data comes back one cycle after issue, tagged with its element index and a valid strobe. Store data is taken from an input that the requester drives according to the exposed next-store index.

A second, lower-priority port carries single-word I/O reads and writes. It gets a cycle only when the vector side issues nothing and the word it wants sits in an idle bank.

Top module: `bank_interleave_ctrl`

## Requirements
- R1: The bank of a word address is its lowest four bits (sixteen banks over 1024 words), so a stride of 17 visits a new bank every element and runs at full rate.
- R2: A bank accessed in cycle t, by either port, is not accessed again before cycle t+4.
- R3: The first element issues in the cycle after a start is accepted, and each following element issues in the next cycle in which its bank is idle; with a stride of 1, L elements take L consecutive cycles.
- R4: A stride that is a multiple of 16 issues exactly one element every 4 cycles.
- R5: Elements issue in increasing index order; a load element's data appears one cycle after its `vecIssue` with `outValid`=1, `outIsIo`=0 and `outIdx` equal to its index.
- R6: Element i of a store writes, to word (first address + i*stride) mod 1024, the `storeData` value present while `storeIdx` equals i.
- R7: `vecStart` is ignored while `vecBusy` is 1 and when `vecLen` is 0; lengths 1 to 64 are honoured and larger values act as 64.
- R8: An I/O request is granted in exactly those cycles in which `ioReq` is 1, no vector element issues and the target bank is idle; a granted I/O read returns data one cycle later with `outValid`=1 and `outIsIo`=1.
- R9: When a vector element can issue, it takes the cycle and a pending I/O request waits.
- R10: After reset no transfer is active, nothing issues and `outValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vecStart | input | 1 | Start pulse for a vector transfer |
| vecWrite | input | 1 | 1 = store, 0 = load |
| vecBase | input | 10 | First word address |
| vecLen | input | 7 | Element count |
| vecStride | input | 10 | Address step, modulo 1024 |
| storeIdx | output | 6 | Index of the next element to issue |
| storeData | input | 64 | Store data for element `storeIdx` |
| vecBusy | output | 1 | A vector transfer is in progress |
| vecIssue | output | 1 | A vector element is issued this cycle |
| ioReq | input | 1 | I/O request pending |
| ioWrite | input | 1 | 1 = I/O write, 0 = I/O read |
| ioAddr | input | 10 | I/O word address |
| ioWdata | input | 64 | I/O write data |
| ioGrant | output | 1 | I/O request served this cycle |
| outValid | output | 1 | Read data valid |
| outIsIo | output | 1 | Read data belongs to the I/O port |
| outIdx | output | 6 | Element index of the read data |
| outData | output | 64 | Read data |

## Verification
A busy counter that drops too early lets two accesses reach one bank inside the recovery window. This shows within a few cycles as an element issued earlier than the bank model predicts. A counter that sticks, or an address step that goes wrong, shows as a late issue cycle or as load data that does not match the bench's memory image, on the very transfer where it happens. Arbitration faults show as an I/O grant in a cycle that a vector element should own, or as a first grant that comes earlier or later than the cycle computed from the vector's bank schedule.

// File: rtl/bic_pkg.sv
package bic_pkg;

  // Strobes the control sends to the datapath each cycle.
  typedef struct packed {
    logic vecGo;  // a vector element accesses memory
    logic ioGo;   // the I/O request accesses memory
    logic wrEn;   // direction of the access
  } memStrobe_t;

endpackage

// File: rtl/bic_ctrl.sv
module bic_ctrl
  import bic_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BANK_BITS = 4,
  parameter int MAX_LEN   = 64,
  localparam int NBANK    = 1 << BANK_BITS,
  localparam int IDX_W    = $clog2(MAX_LEN),
  localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vecStart,
  input  logic              vecWrite,
  input  logic [ADDR_W-1:0] vecBase,
  input  logic [LEN_W-1:0]  vecLen,
  input  logic [ADDR_W-1:0] vecStride,
  input  logic              ioReq,
  input  logic              ioWrite,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [NBANK-1:0]  bankBusy,
  output memStrobe_t        strb,
  output logic [ADDR_W-1:0] accAddr,
  output logic [IDX_W-1:0]  accIdx,
  output logic              vecActive
);

  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

  logic              active;
  logic              wrMode;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] stride;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  lastIdx;
  logic [LEN_W-1:0]  lenEff;
  logic              vecGo;
  logic              ioGo;

  // Issue and arbitration: the vector side owns any cycle it can use.
  always_comb begin
    vecGo = active && !bankBusy[curAddr[BANK_BITS-1:0]];
    ioGo  = ioReq && !vecGo && !bankBusy[ioAddr[BANK_BITS-1:0]];
    strb.vecGo = vecGo;
    strb.ioGo  = ioGo;
    strb.wrEn  = vecGo ? wrMode : ioWrite;
    accAddr    = vecGo ? curAddr : ioAddr;
    accIdx     = idx;
  end

  assign lenEff    = (vecLen > LEN_CAP) ? LEN_CAP : vecLen;
  assign vecActive = active;

  // Element sequencer: strictly in index order.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      wrMode  <= 1'b0;
      curAddr <= '0;
      stride  <= '0;
      idx     <= '0;
      lastIdx <= '0;
    end else if (!active) begin
      if (vecStart && (vecLen != '0)) begin
        active  <= 1'b1;
        wrMode  <= vecWrite;
        curAddr <= vecBase;
        stride  <= vecStride;
        idx     <= '0;
        lastIdx <= IDX_W'(lenEff - 1'b1);
      end
    end else if (vecGo) begin
      if (idx == lastIdx) begin
        active <= 1'b0;
      end else begin
        idx     <= idx + 1'b1;
        curAddr <= curAddr + stride;
      end
    end
  end

endmodule

// File: rtl/bic_datapath.sv
module bic_datapath
  import bic_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 64,
  parameter int BANK_BITS = 4,
  parameter int BUSY_CYC  = 4,
  parameter int MAX_LEN   = 64,
  localparam int NBANK    = 1 << BANK_BITS,
  localparam int ROW_W    = ADDR_W - BANK_BITS,
  localparam int DEPTH    = 1 << ROW_W,
  localparam int CNT_W    = $clog2(BUSY_CYC),
  localparam int IDX_W    = $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strb,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [IDX_W-1:0]  accIdx,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] ioWdata,
  output logic [NBANK-1:0]  bankBusy,
  output logic              outValid,
  output logic              outIsIo,
  output logic [IDX_W-1:0]  outIdx,
  output logic [DATA_W-1:0] outData
);

  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BUSY_CYC - 1);

  logic                 anyAcc;
  logic [BANK_BITS-1:0] accBank;
  logic [ROW_W-1:0]     accRow;
  logic [DATA_W-1:0]    wrData;
  logic [BANK_BITS-1:0] selBank;
  logic [DATA_W-1:0]    bankRd [NBANK];

  assign anyAcc  = strb.vecGo || strb.ioGo;
  assign accBank = accAddr[BANK_BITS-1:0];
  assign accRow  = accAddr[ADDR_W-1:BANK_BITS];
  assign wrData  = strb.vecGo ? storeData : ioWdata;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdReg;
    logic [CNT_W-1:0]  busyCnt;
    logic              hit;

    assign hit         = anyAcc && (accBank == BANK_BITS'(g));
    assign bankBusy[g] = (busyCnt != '0);
    assign bankRd[g]   = rdReg;

    // Recovery counter: loaded on access, counts down to idle.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        busyCnt <= '0;
      end else if (hit) begin
        busyCnt <= RELOAD;
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (hit && strb.wrEn) begin
        mem[accRow] <= wrData;
      end
      if (hit && !strb.wrEn) begin
        rdReg <= mem[accRow];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outIsIo  <= 1'b0;
      outIdx   <= '0;
      selBank  <= '0;
    end else begin
      outValid <= anyAcc && !strb.wrEn;
      outIsIo  <= strb.ioGo && !strb.wrEn;
      outIdx   <= accIdx;
      selBank  <= accBank;
    end
  end

  assign outData = bankRd[selBank];

endmodule

// File: rtl/bank_interleave_ctrl.sv
module bank_interleave_ctrl
  import bic_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 64,
  parameter int BANK_BITS = 4,
  parameter int BUSY_CYC  = 4,
  parameter int MAX_LEN   = 64,
  localparam int NBANK    = 1 << BANK_BITS,
  localparam int IDX_W    = $clog2(MAX_LEN),
  localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vecStart,
  input  logic              vecWrite,
  input  logic [ADDR_W-1:0] vecBase,
  input  logic [LEN_W-1:0]  vecLen,
  input  logic [ADDR_W-1:0] vecStride,
  output logic [IDX_W-1:0]  storeIdx,
  input  logic [DATA_W-1:0] storeData,
  output logic              vecBusy,
  output logic              vecIssue,
  input  logic              ioReq,
  input  logic              ioWrite,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioWdata,
  output logic              ioGrant,
  output logic              outValid,
  output logic              outIsIo,
  output logic [IDX_W-1:0]  outIdx,
  output logic [DATA_W-1:0] outData
);

  memStrobe_t           strb;
  logic [ADDR_W-1:0]    accAddr;
  logic [IDX_W-1:0]     accIdx;
  logic [NBANK-1:0]     bankBusy;
  logic                 accWrite;
  logic [BANK_BITS-1:0] accBank;

  bic_ctrl #(
    .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .MAX_LEN(MAX_LEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .vecStart(vecStart), .vecWrite(vecWrite), .vecBase(vecBase),
    .vecLen(vecLen), .vecStride(vecStride),
    .ioReq(ioReq), .ioWrite(ioWrite), .ioAddr(ioAddr),
    .bankBusy(bankBusy), .strb(strb), .accAddr(accAddr),
    .accIdx(accIdx), .vecActive(vecBusy)
  );

  bic_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_BITS(BANK_BITS),
    .BUSY_CYC(BUSY_CYC), .MAX_LEN(MAX_LEN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .accAddr(accAddr),
    .accIdx(accIdx), .storeData(storeData), .ioWdata(ioWdata),
    .bankBusy(bankBusy), .outValid(outValid), .outIsIo(outIsIo),
    .outIdx(outIdx), .outData(outData)
  );

  assign storeIdx = accIdx;
  assign vecIssue = strb.vecGo;
  assign ioGrant  = strb.ioGo;
  assign accWrite = strb.wrEn;
  assign accBank  = accAddr[BANK_BITS-1:0];

endmodule

// File: rtl/bank_interleave_ctrl_checker.sv
module bank_interleave_ctrl_checker #(
  parameter int BANK_BITS = 4,
  parameter int BUSY_CYC  = 4,
  localparam int NBANK    = 1 << BANK_BITS,
  localparam int CNT_W    = $clog2(BUSY_CYC + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 vecIssue,
  input logic                 ioGrant,
  input logic                 vecBusy,
  input logic                 accWrite,
  input logic [BANK_BITS-1:0] accBank,
  input logic                 outValid,
  input logic                 outIsIo
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BUSY_CYC);

  logic anyAcc;
  assign anyAcc = vecIssue || ioGrant;

  // Cycles since each bank's last access, saturating at the recovery time.
  for (genvar g = 0; g < NBANK; g++) begin : g_rest
    logic [CNT_W-1:0] sinceAcc;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        sinceAcc <= LIMIT;
      end else if (anyAcc && (accBank == BANK_BITS'(g))) begin
        sinceAcc <= CNT_W'(1);
      end else if (sinceAcc < LIMIT) begin
        sinceAcc <= sinceAcc + 1'b1;
      end
    end

    assert_bank_rest_R2: assert property (@(posedge clk) disable iff (!rstN)
      (anyAcc && (accBank == BANK_BITS'(g))) |-> (sinceAcc >= LIMIT));
  end

  assert_vector_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(vecIssue && ioGrant));

  assert_issue_needs_transfer_R7: assert property (@(posedge clk) disable iff (!rstN)
    vecIssue |-> vecBusy);

  assert_load_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    (vecIssue && !accWrite) |=> (outValid && !outIsIo));

  assert_io_read_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ioGrant && !accWrite) |=> (outValid && outIsIo));

endmodule

bind bank_interleave_ctrl bank_interleave_ctrl_checker #(
  .BANK_BITS(BANK_BITS), .BUSY_CYC(BUSY_CYC)
) u_chk (
  .clk(clk), .rstN(rstN), .vecIssue(vecIssue), .ioGrant(ioGrant),
  .vecBusy(vecBusy), .accWrite(accWrite), .accBank(accBank),
  .outValid(outValid), .outIsIo(outIsIo)
);

// File: tb/bank_interleave_ctrl_bench.sv
module bank_interleave_ctrl_bench;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 64;
  localparam int LEN_W  = 7;
  localparam int IDX_W  = 6;
  localparam int WORDS  = 1024;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              vecStart = 1'b0;
  logic              vecWrite = 1'b0;
  logic [ADDR_W-1:0] vecBase = '0;
  logic [LEN_W-1:0]  vecLen = '0;
  logic [ADDR_W-1:0] vecStride = '0;
  logic [IDX_W-1:0]  storeIdx;
  logic [DATA_W-1:0] storeData = '0;
  logic              vecBusy;
  logic              vecIssue;
  logic              ioReq = 1'b0;
  logic              ioWrite = 1'b0;
  logic [ADDR_W-1:0] ioAddr = '0;
  logic [DATA_W-1:0] ioWdata = '0;
  logic              ioGrant;
  logic              outValid;
  logic              outIsIo;
  logic [IDX_W-1:0]  outIdx;
  logic [DATA_W-1:0] outData;

  bank_interleave_ctrl u_bank_interleave_ctrl (
    .clk(clk), .rstN(rstN), .vecStart(vecStart), .vecWrite(vecWrite),
    .vecBase(vecBase), .vecLen(vecLen), .vecStride(vecStride),
    .storeIdx(storeIdx), .storeData(storeData), .vecBusy(vecBusy),
    .vecIssue(vecIssue), .ioReq(ioReq), .ioWrite(ioWrite),
    .ioAddr(ioAddr), .ioWdata(ioWdata), .ioGrant(ioGrant),
    .outValid(outValid), .outIsIo(outIsIo), .outIdx(outIdx),
    .outData(outData)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int startNeg = 0;
  int issueCount = 0;
  int issueCyc [64];
  logic [DATA_W-1:0] rdData [64];
  int rdNext = 0;
  bit orderErr = 0;
  int ioFirstGrant = -1;
  logic [31:0] salt = 32'h1;
  logic [DATA_W-1:0] refMem [WORDS];

  function automatic logic [DATA_W-1:0] patFn(input int idx, input logic [31:0] s);
    return {s ^ 32'h5A17_C3E1, (32'(idx) * 32'h0100_0193) ^ 32'hA5A5_0000};
  endfunction

  function automatic int elemAddr(input int base, input int stride, input int i);
    return (base + i * stride) % WORDS;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor, away from the active edge.
  always @(negedge clk) begin
    if (vecStart && !vecBusy) startNeg = cyc;
    if (vecIssue) begin
      if (issueCount < 64) issueCyc[issueCount] = cyc;
      issueCount++;
    end
    if (outValid && !outIsIo) begin
      if (int'(outIdx) != rdNext) orderErr = 1;
      rdData[outIdx] = outData;
      rdNext++;
    end
    if (ioGrant && ioFirstGrant < 0) ioFirstGrant = cyc;
    cyc++;
  end

  // Store data follows the exposed next-store index.
  always @(posedge clk) begin
    #1;
    storeData = patFn(int'(storeIdx), salt);
  end

  task automatic drvStep();
    @(posedge clk);
    #1;
  endtask

  task automatic startVec(input bit w, input int base, input int len, input int stride);
    drvStep();
    salt = salt * 32'd1103515245 + 32'd12345;
    vecWrite = w;
    vecBase = ADDR_W'(base);
    vecLen = LEN_W'(len);
    vecStride = ADDR_W'(stride);
    issueCount = 0;
    rdNext = 0;
    orderErr = 0;
    vecStart = 1'b1;
    drvStep();
    vecStart = 1'b0;
  endtask

  task automatic waitVec();
    @(negedge clk);
    while (vecBusy) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  // Expected issue schedule from the bank model, then data and memory image.
  task automatic checkVec(input bit w, input int base, input int len,
                          input int stride, input string tag);
    int ready [16];
    int t;
    int badT;
    int badE;
    int errs;
    int dErr;
    logic [63:0] dAct;
    logic [63:0] dExp;
    for (int b = 0; b < 16; b++) ready[b] = 0;
    t = startNeg + 1;
    errs = 0;
    badT = 0;
    badE = 0;
    for (int i = 0; i < len; i++) begin
      int a;
      int b;
      a = elemAddr(base, stride, i);
      b = a % 16;
      if (t < ready[b]) t = ready[b];
      if (i >= issueCount || issueCyc[i] != t) begin
        if (errs == 0) begin
          badT = (i < issueCount) ? issueCyc[i] : -1;
          badE = t;
        end
        errs++;
      end
      ready[b] = t + 4;
      t++;
    end
    check(errs == 0 && issueCount == len, {tag, " issue schedule"},
          64'(badT), 64'(badE));
    if (w) begin
      for (int i = 0; i < len; i++)
        refMem[elemAddr(base, stride, i)] = patFn(i, salt);
    end else begin
      dErr = 0;
      dAct = '0;
      dExp = '0;
      for (int i = 0; i < len; i++) begin
        if (rdData[i] !== refMem[elemAddr(base, stride, i)]) begin
          if (dErr == 0) begin
            dAct = rdData[i];
            dExp = refMem[elemAddr(base, stride, i)];
          end
          dErr++;
        end
      end
      check(dErr == 0, {tag, " R5,R6 load data"}, dAct, dExp);
      check(!orderErr && rdNext == len, {tag, " R5 order and count"},
            64'(rdNext), 64'(len));
    end
  endtask

  task automatic runVec(input bit w, input int base, input int len,
                        input int stride, input string tag);
    startVec(w, base, len, stride);
    waitVec();
    checkVec(w, base, len, stride, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R10: reset state
    @(negedge clk);
    check(!vecBusy && !vecIssue && !outValid && !ioGrant, "R10 reset state",
          {60'd0, vecBusy, vecIssue, outValid, ioGrant}, 64'd0);

    // R3, R6: fill the memory at full rate with stride 1
    for (int k = 0; k < 16; k++) runVec(1'b1, k * 64, 64, 1, "R3 fill");
    // R6: read everything back
    for (int k = 0; k < 16; k++) runVec(1'b0, k * 64, 64, 1, "R3 R6 readback");

    // R4: same bank every element
    runVec(1'b0, 7, 8, 16, "R4 stride16");
    check(issueCyc[1] - issueCyc[0] == 4, "R4 spacing",
          64'(issueCyc[1] - issueCyc[0]), 64'd4);
    runVec(1'b1, 32, 6, 48, "R4 stride48 store");
    runVec(1'b0, 32, 6, 48, "R4 stride48 load");

    // R1: stride 17 visits a new bank each element
    runVec(1'b0, 5, 16, 17, "R1 stride17");
    check(issueCyc[15] - issueCyc[0] == 15, "R1 full rate",
          64'(issueCyc[15] - issueCyc[0]), 64'd15);

    // R2: two banks alternating
    runVec(1'b0, 0, 10, 8, "R2 stride8");
    check(issueCyc[2] - issueCyc[0] == 4, "R2 recovery",
          64'(issueCyc[2] - issueCyc[0]), 64'd4);

    // R7: length 1, length 64 with wrap, length 0 ignored
    runVec(1'b0, 1023, 1, 1, "R7 len1");
    runVec(1'b0, 1000, 64, 3, "R7 len64 wrap");
    startVec(1'b0, 0, 0, 1);
    repeat (3) @(negedge clk);
    check(!vecBusy && issueCount == 0, "R7 zero length ignored",
          64'(issueCount), 64'd0);

    // R7: start while busy ignored
    startVec(1'b0, 2, 8, 16);
    drvStep();
    vecBase = 10'd3;
    vecStride = 10'd1;
    vecLen = 7'd2;
    vecStart = 1'b1;
    drvStep();
    vecStart = 1'b0;
    waitVec();
    checkVec(1'b0, 2, 8, 16, "R7 start while busy");

    // R8, R2: I/O alone, write then read of the same bank
    drvStep();
    ioReq = 1'b1;
    ioWrite = 1'b1;
    ioAddr = 10'd100;
    ioWdata = 64'hDEAD_BEEF_0123_4567;
    @(negedge clk);
    check(ioGrant, "R8 idle write grant", 64'(ioGrant), 64'd1);
    drvStep();
    ioWrite = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ioGrant && n < 10);
    check(n == 4, "R2 io read waits for bank", 64'(n), 64'd4);
    drvStep();
    ioReq = 1'b0;
    @(negedge clk);
    check(outValid && outIsIo && outData == 64'hDEAD_BEEF_0123_4567,
          "R8 io read data", outData, 64'hDEAD_BEEF_0123_4567);
    refMem[100] = 64'hDEAD_BEEF_0123_4567;
    repeat (5) @(negedge clk);

    // R9: vector issuing every cycle keeps the I/O port out
    startVec(1'b0, 0, 16, 1);
    ioFirstGrant = -1;
    ioReq = 1'b1;
    ioWrite = 1'b0;
    ioAddr = 10'd3;
    waitVec();
    check(ioFirstGrant == startNeg + 17, "R9 io waits for full-rate vector",
          64'(ioFirstGrant), 64'(startNeg + 17));
    drvStep();
    ioReq = 1'b0;
    checkVec(1'b0, 0, 16, 1, "R9 vector unaffected");
    repeat (5) @(negedge clk);

    // R8: I/O to another bank uses the stall cycles
    startVec(1'b0, 0, 4, 16);
    ioFirstGrant = -1;
    ioReq = 1'b1;
    ioAddr = 10'd5;
    waitVec();
    check(ioFirstGrant == startNeg + 2, "R8 io uses stall cycle",
          64'(ioFirstGrant), 64'(startNeg + 2));
    drvStep();
    ioReq = 1'b0;
    checkVec(1'b0, 0, 4, 16, "R8 vector unaffected");
    repeat (5) @(negedge clk);

    // R9: I/O to the vector's own bank waits for the whole transfer
    startVec(1'b0, 0, 4, 16);
    ioFirstGrant = -1;
    ioReq = 1'b1;
    ioAddr = 10'd16;
    waitVec();
    @(negedge clk);
    check(ioFirstGrant == startNeg + 17, "R9 io same bank",
          64'(ioFirstGrant), 64'(startNeg + 17));
    drvStep();
    ioReq = 1'b0;
    repeat (5) @(negedge clk);

    // Random transfers: R1, R2, R3, R4 schedule and R5, R6 data
    for (int k = 0; k < 40; k++) begin
      bit w;
      int base;
      int len;
      int stride;
      w = 1'($urandom % 2);
      base = int'($urandom % WORDS);
      len = 1 + int'($urandom % 64);
      case ($urandom % 8)
        0: stride = 1;
        1: stride = 2;
        2: stride = 3;
        3: stride = 4;
        4: stride = 8;
        5: stride = 16;
        6: stride = 32;
        default: stride = int'($urandom % WORDS);
      endcase
      runVec(w, base, len, stride, "R1 R2 R3 R4 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule